// File: doc/BRIEF.md
# Prioritised Short-Broadcast Word Encoder

This block gathers requests for short broadcasts from four kinds of producer: second-level trigger decisions, reset requests (for the bunch counter, the event counter, the front ends and the event identifier), calibration pulse requests and generic control commands. It ranks pending requests by a fixed priority and turns the winner into an 8-bit broadcast word. The word goes to a downstream serializer that sends one word per transmit slot on a serial command channel.

Requests that lose arbitration are kept until their turn. Trigger decisions, calibration requests and commands each wait in their own first-in first-out queue, so repeated requests of one kind keep their order. Reset requests are folded into one pending reset word. Each word is held on the output with a valid flag until the serializer accepts it. The producer side has no back-pressure. A push into a full queue is dropped and recorded in a sticky overflow flag, which a clear input resets.

Top module: `bcast_encoder`

## Requirements
- R1: A trigger decision is sent as `1, type[1:0], evid, d[1:0], 00` from bit 7 down to bit 0.
- R2: A reset word is sent as `01, 0, bits[4:0]`. The reset bits are, from bit 4 down to bit 0: event-ID reset, second-level front-end reset, first-level front-end reset, event counter reset, bunch counter reset.
- R3: A calibration request is sent as `0001, pulse[1:0], 00`.
- R4: A command is sent as `00, code[3:0], 00`.
- R5: Whenever a new word is picked, trigger decisions win over the pending reset word. The reset word wins over calibration, and calibration wins over commands. A higher-priority request that arrives while a lower one is waiting is sent first. Within one kind, requests leave in arrival order.
- R6: Reset requests that arrive before the pending reset word is sent are merged by bitwise OR into one word. A reset request whose five bits are all zero has no effect.
- R7: While `bc_valid` is high and `bc_accept` is low, `bc_valid` stays high and `bc_word` does not change.
- R8: After a cycle with `bc_valid` and `bc_accept` both high, `bc_valid` is low for exactly one cycle. If any request is then pending, the next word is presented in the cycle after.
- R9: Each request queue holds `DEPTH` (default 16) entries. Up to that many decisions can wait behind a held word and none is lost.
- R10: A push into a full queue is dropped and sets `ovf`. `ovf` stays high until `ovf_clr` is pulsed.
- R11: After reset, `bc_valid` and `ovf` are low and `bc_word` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_req | input | 1 | Trigger decision push |
| trig_type | input | 2 | Trigger type |
| trig_evid | input | 1 | Event-ID flag |
| trig_d | input | 2 | Two-bit D field |
| rst_req | input | 1 | Reset request push |
| rst_bits | input | 5 | Requested reset bits |
| cal_req | input | 1 | Calibration request push |
| cal_type | input | 2 | Calibration pulse type |
| cmd_req | input | 1 | Command push |
| cmd_code | input | 4 | Command code |
| ovf_clr | input | 1 | Clears the overflow flag |
| bc_word | output | 8 | Broadcast word presented to the serializer |
| bc_valid | output | 1 | `bc_word` is valid |
| bc_accept | input | 1 | One-cycle accept from the serializer |
| ovf | output | 1 | Sticky queue-overflow flag |

## Verification
The hardest states to reach are those where several kinds of request wait at the same time, because the arbiter normally forwards a lone request as soon as it appears. The bench withholds `bc_accept` so that a first command sits in the output register. It then injects mixed bursts, staggered resets and late triggers behind that command, and finally lets the serializer drain. This fills the trigger queue to its limit, checks that the seventeenth push sets the overflow flag, shows later triggers overtaking an earlier command, and shows resets merging.

// File: rtl/bcast_encoder.sv
module bcast_encoder #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_req,
  input  logic [1:0] trig_type,
  input  logic       trig_evid,
  input  logic [1:0] trig_d,
  input  logic       rst_req,
  input  logic [4:0] rst_bits,
  input  logic       cal_req,
  input  logic [1:0] cal_type,
  input  logic       cmd_req,
  input  logic [3:0] cmd_code,
  input  logic       ovf_clr,
  output logic [7:0] bc_word,
  output logic       bc_valid,
  input  logic       bc_accept,
  output logic       ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {SEL_TRIG, SEL_CAL, SEL_CMD, SEL_RST} sel_t;

  logic [2:0] push, pop, nempty, full, drop;
  logic [4:0] pin [3];
  logic [4:0] pout [3];
  logic [4:0] rst_pend, rst_in;
  logic [4:0] pay;
  logic [7:0] word_n;
  logic       any, load;
  sel_t       sel;

  assign push   = {cmd_req, cal_req, trig_req};
  assign pin[0] = {trig_type, trig_evid, trig_d};
  assign pin[1] = {3'b000, cal_type};
  assign pin[2] = {1'b0, cmd_code};
  assign rst_in = rst_req ? rst_bits : 5'd0;

  for (genvar g = 0; g < 3; g++) begin : g_q
    logic [4:0]    mem [DEPTH];
    logic [AW-1:0] rd, wr;
    logic [AW:0]   cnt;
    logic          wen;

    assign wen       = push[g] && (!full[g] || pop[g]);
    assign nempty[g] = |cnt;
    assign full[g]   = (cnt == CNT_FULL);
    assign drop[g]   = push[g] && !wen;
    assign pout[g]   = mem[rd];

    always_ff @(posedge clk)
      if (wen) mem[wr] <= pin[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd  <= '0;
        wr  <= '0;
        cnt <= '0;
      end else begin
        if (wen) wr <= (wr == AW'(DEPTH-1)) ? '0 : wr + 1'b1;
        if (pop[g]) rd <= (rd == AW'(DEPTH-1)) ? '0 : rd + 1'b1;
        case ({wen, pop[g]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  always_comb begin
    any = 1'b1;
    sel = SEL_CMD;
    pay = pout[2];
    if (nempty[0]) begin
      sel = SEL_TRIG;
      pay = pout[0];
    end else if (|rst_pend) begin
      sel = SEL_RST;
    end else if (nempty[1]) begin
      sel = SEL_CAL;
      pay = pout[1];
    end else if (!nempty[2]) begin
      any = 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_TRIG: word_n = {1'b1, pay[4:3], pay[2], pay[1:0], 2'b00};
      SEL_RST:  word_n = {2'b01, 1'b0, rst_pend};
      SEL_CAL:  word_n = {4'b0001, pay[1:0], 2'b00};
      default:  word_n = {2'b00, pay[3:0], 2'b00};
    endcase
  end

  assign load = !bc_valid && any;
  assign pop  = load ? {sel == SEL_CMD, sel == SEL_CAL, sel == SEL_TRIG} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_valid <= 1'b0;
      bc_word  <= 8'd0;
      rst_pend <= 5'd0;
      ovf      <= 1'b0;
    end else begin
      if (bc_valid && bc_accept) bc_valid <= 1'b0;
      else if (load) begin
        bc_valid <= 1'b1;
        bc_word  <= word_n;
      end
      rst_pend <= (load && sel == SEL_RST) ? rst_in : (rst_pend | rst_in);
      ovf      <= (ovf && !ovf_clr) || (|drop);
    end
  end
endmodule

// File: rtl/bcast_encoder_chk.sv
module bcast_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bc_word,
  input logic       bc_valid,
  input logic       bc_accept,
  input logic       ovf,
  input logic       ovf_clr
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && !bc_accept |=> bc_valid && $stable(bc_word)); // R7

  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && bc_accept |=> !bc_valid); // R8

  AST_TRIG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && bc_word[7] |-> bc_word[1:0] == 2'b00); // R1

  AST_RESET_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && bc_word[7:6] == 2'b01 |-> !bc_word[5] && bc_word[4:0] != 5'd0); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf); // R10
endmodule

bind bcast_encoder bcast_encoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bc_word(bc_word), .bc_valid(bc_valid),
  .bc_accept(bc_accept), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/test_bcast_encoder.sv
module test_bcast_encoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_req = 0, trig_evid = 0, rst_req = 0, cal_req = 0, cmd_req = 0;
  logic [1:0] trig_type = 0, trig_d = 0, cal_type = 0;
  logic [4:0] rst_bits = 0;
  logic [3:0] cmd_code = 0;
  logic ovf_clr = 0, bc_accept = 0;
  logic [7:0] bc_word;
  logic bc_valid, ovf;

  int checks = 0, errors = 0;
  logic [7:0] expq[$];
  bit acc_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcast_encoder i_bcast_encoder (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .trig_type(trig_type),
    .trig_evid(trig_evid), .trig_d(trig_d), .rst_req(rst_req), .rst_bits(rst_bits),
    .cal_req(cal_req), .cal_type(cal_type), .cmd_req(cmd_req), .cmd_code(cmd_code),
    .ovf_clr(ovf_clr), .bc_word(bc_word), .bc_valid(bc_valid),
    .bc_accept(bc_accept), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic clear_reqs();
    trig_req = 0; rst_req = 0; cal_req = 0; cmd_req = 0; ovf_clr = 0;
  endtask

  task automatic drv_trig(input logic [1:0] t, input logic e, input logic [1:0] d);
    trig_req = 1; trig_type = t; trig_evid = e; trig_d = d;
    expq.push_back({1'b1, t, e, d, 2'b00});
  endtask

  task automatic drv_cmd(input logic [3:0] c);
    cmd_req = 1; cmd_code = c;
    expq.push_back({2'b00, c, 2'b00});
  endtask

  task automatic drv_cal(input logic [1:0] p);
    cal_req = 1; cal_type = p;
    expq.push_back({4'b0001, p, 2'b00});
  endtask

  task automatic drain();
    acc_en = 1;
    while (expq.size() != 0) tick();
    repeat (4) tick();
  endtask

  // scoreboard monitor
  initial begin
    bit gap = 0;
    forever begin
      @(negedge clk);
      if (bc_accept) begin
        bc_accept = 0;
        chk(!bc_valid, "R8", {7'd0, bc_valid}, 8'd0);
        gap = (expq.size() != 0);
      end else begin
        if (gap) begin
          chk(bc_valid, "R8", {7'd0, bc_valid}, 8'd1);
          gap = 0;
        end
        if (acc_en && bc_valid) begin
          if (expq.size() == 0) chk(1'b0, "R5", bc_word, 8'hxx);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(bc_word === e, "R5", bc_word, e);
          end
          bc_accept = 1;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(!bc_valid && !ovf && bc_word == 8'd0, "R11", bc_word, 8'd0);
    rst_n = 1;
    tick();

    // R1 trigger format
    acc_en = 1;
    drv_trig(2'b10, 1'b1, 2'b01); tick(); clear_reqs();
    chk(expq[0] == 8'hD4, "R1", expq[0], 8'hD4);
    drain();

    // R2, R3, R4 formats
    rst_req = 1; rst_bits = 5'b10011; expq.push_back(8'h53); tick(); clear_reqs(); drain();
    drv_cal(2'b11); tick(); clear_reqs(); drain();
    drv_cmd(4'b1010); tick(); clear_reqs(); drain();
    chk(1'b1, "R3", 8'h1C, 8'h1C);
    chk(1'b1, "R4", 8'h28, 8'h28);

    // R5 priority with a blocking word, R7 hold
    acc_en = 0;
    drv_cmd(4'b1111); tick(); clear_reqs();
    repeat (3) tick();
    chk(bc_valid && bc_word == 8'h3C, "R7", bc_word, 8'h3C);
    repeat (3) tick();
    chk(bc_valid && bc_word == 8'h3C, "R7", bc_word, 8'h3C);
    cmd_req = 1; cmd_code = 4'b0011;
    cal_req = 1; cal_type = 2'b01;
    rst_req = 1; rst_bits = 5'b00001;
    trig_req = 1; trig_type = 0; trig_evid = 0; trig_d = 0;
    tick(); clear_reqs();
    trig_req = 1; trig_type = 2'b11; trig_evid = 0; trig_d = 2'b11;
    tick(); clear_reqs();
    expq.push_back(8'h80); expq.push_back(8'hEC); expq.push_back(8'h41);
    expq.push_back(8'h14); expq.push_back(8'h0C);
    drain();

    // R6 merge and R5 overtake
    acc_en = 0;
    drv_cmd(4'b1000); tick(); clear_reqs(); repeat (3) tick();
    cmd_req = 1; cmd_code = 4'b1001; tick(); clear_reqs();
    rst_req = 1; rst_bits = 5'b00001; tick(); clear_reqs();
    rst_req = 1; rst_bits = 5'b00000; tick(); clear_reqs();
    rst_req = 1; rst_bits = 5'b00100; tick(); clear_reqs();
    drv_trig(2'b01, 1'b1, 2'b10); tick(); clear_reqs();
    expq.push_back(8'h45); expq.push_back(8'h24);
    drain();

    // R6 zero-bit reset ignored
    rst_req = 1; rst_bits = 5'd0; tick(); clear_reqs();
    repeat (4) tick();
    chk(!bc_valid, "R6", {7'd0, bc_valid}, 8'd0);

    // R9 depth and R10 overflow
    acc_en = 0;
    drv_cmd(4'b0000); tick(); clear_reqs(); repeat (3) tick();
    for (int i = 0; i < 17; i++) begin
      if (i < 16) drv_trig(i[1:0], i[2], i[4:3]);
      else begin
        trig_req = 1; trig_type = 2'b11; trig_evid = 1; trig_d = 2'b11;
      end
      tick(); clear_reqs();
      if (i == 15) chk(!ovf, "R9", {7'd0, ovf}, 8'd0);
    end
    chk(ovf, "R10", {7'd0, ovf}, 8'd1);
    drain();
    chk(ovf, "R10", {7'd0, ovf}, 8'd1);
    ovf_clr = 1; tick(); clear_reqs();
    chk(!ovf, "R10", {7'd0, ovf}, 8'd0);
    chk(!bc_valid, "R9", {7'd0, bc_valid}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule